// File: doc/BRIEF.md
# Oversampled Asynchronous Frame Receiver

This block recovers fixed-length words from a continuous, free-running serial line. The line is not a standard UART format, and the bit rate is about 400 kbit/s. The block does not run on a bit clock. Instead it samples the line on a clock enable that pulses a little more than five times per bit period.

A phase counter divides each bit period into five sample slots. A bit counter walks through the sixteen bit periods of a word. Each word is laid out as follows:

| Field | Bit periods | Line level |
|---|---|---|
| Start | 4 | low |
| Data | 10 | as sent |
| Stop | 2 | high |

Each bit is sampled in its third slot, so the sample falls near the middle of the bit.

Before the block trusts the framing, it requires two qualifying periods on the line:

- **Stop qualification:** a high period of at least 1.5 bit times.
- **Start qualification:** a start period of at least 3.5 bit times.

A start that ends early is treated as noise, and the block returns to waiting for a stop period. When a word is complete, the block presents it with a one-cycle valid strobe and a flag that reports whether the second stop bit was wrong.

Top module: `osrx_frame_rx`

## Requirements
- R1: A synchronous active-high reset clears `dataValid`, `stopErr` and `dataOut` to zero by the following cycle. It also returns the receiver to stop hunting.
- R2: After reset or after a frame with a stop error, no frame is accepted until the line has been high on at least 8 consecutive sample ticks. Eight ticks is 1.5 bit times rounded up to whole ticks.
- R3: Once a start has been seen, the line must stay low on every sample tick from the first low tick through the sample of the fourth start bit. That is 18 ticks, or at least 3.5 bit times. A high tick before then abandons the attempt with no valid strobe, and the receiver returns to the stop hunt of R2.
- R4: While the receiver waits for a start, the phase and bit counters are held at zero. Tick 0 is the first low tick. Bit k is sampled on tick 5k+2, and the bit counter advances there. Clock cycles without `tickEn` change nothing.
- R5: The ten data bits follow the four start bits. The first data bit received ends up in `dataOut[9]`, and the last one in `dataOut[0]`.
- R6: `dataValid` is a one-cycle pulse. It rises in the clock cycle after the tick that samples the second stop bit, which is tick 77 of the frame. `dataOut` and `stopErr` change only together with that pulse and hold their values until the next pulse.
- R7: `stopErr` is 1 when the second stop bit samples low and 0 when it samples high. The value of the first stop bit has no effect on `stopErr` or on acceptance.
- R8: After a frame without a stop error, the receiver waits for the next start at once, so frames sent back to back with no idle are all received. After a frame with a stop error, it goes back to the stop hunt of R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tickEn | input | 1 | Oversample enable, slightly above 5 pulses per bit period |
| rxIn | input | 1 | Asynchronous serial line; idle and stop level high, start level low |
| dataOut | output | 10 | Last received data word, first-received bit in the MSB |
| dataValid | output | 1 | One-cycle strobe marking a new word |
| stopErr | output | 1 | Set with the strobe when the second stop bit was low |

## Verification
The assertions assume the following about the inputs:

- `tickEn` is a single-cycle pulse separated by more clock cycles than the two-flop synchronizer delay, so a line change is already synchronized by the next tick.
- `rxIn` stays steady across each group of five ticks that makes up a bit.
- The reset is applied from time zero.

The stimulus respects these assumptions. It pulses `tickEn` on every fourth clock. It changes `rxIn` only on the falling clock edge right after a tick, and holds each level for a whole number of ticks. Rate mismatch between sender and receiver is therefore never exercised; every frame is sent at exactly five ticks per bit.

// File: rtl/osrx_pkg.sv
package osrx_pkg;

  typedef enum logic [2:0] {
    ST_HUNT_STOP,
    ST_WAIT_START,
    ST_QUAL_START,
    ST_DATA,
    ST_STOP
  } rxState_t;

  typedef struct packed {
    logic cntClr;
    logic cntStart;
    logic cntRun;
    logic shiftEn;
    logic capture;
    logic huntClr;
    logic huntInc;
  } rxCtl_t;

endpackage

// File: rtl/osrx_datapath.sv
module osrx_datapath
  import osrx_pkg::*;
#(
  parameter int OVS         = 5,
  parameter int START_BITS  = 4,
  parameter int DATA_BITS   = 10,
  parameter int STOP_BITS   = 2,
  localparam int FRAME_BITS = START_BITS + DATA_BITS + STOP_BITS,
  localparam int PHASE_W    = $clog2(OVS),
  localparam int BIT_W      = $clog2(FRAME_BITS + 1),
  localparam int STOP_QUAL  = (3 * OVS + 1) / 2,
  localparam int HUNT_W     = $clog2(STOP_QUAL + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rxIn,
  input  rxCtl_t               ctl,
  output logic                 rxS,
  output logic [PHASE_W-1:0]   phaseCnt,
  output logic [BIT_W-1:0]     bitCnt,
  output logic                 huntDone,
  output logic [DATA_BITS-1:0] dataOut,
  output logic                 dataValid,
  output logic                 stopErr
);

  logic                 rxMeta;
  logic [HUNT_W-1:0]    huntCnt;
  logic [DATA_BITS-1:0] shiftReg;

  localparam logic [PHASE_W-1:0] PHASE_LAST = PHASE_W'(OVS - 1);

  // two-flop synchronizer, idle high
  always_ff @(posedge clk) begin
    if (rst) begin
      rxMeta <= 1'b1;
      rxS    <= 1'b1;
    end else begin
      rxMeta <= rxIn;
      rxS    <= rxMeta;
    end
  end

  // consecutive high-tick counter for stop qualification
  always_ff @(posedge clk) begin
    if (rst || ctl.huntClr)
      huntCnt <= '0;
    else if (ctl.huntInc)
      huntCnt <= huntCnt + 1'b1;
  end

  assign huntDone = (huntCnt >= HUNT_W'(STOP_QUAL - 1));

  // divide-by-OVS phase counter and frame bit counter
  always_ff @(posedge clk) begin
    if (rst || ctl.cntClr) begin
      phaseCnt <= '0;
      bitCnt   <= '0;
    end else if (ctl.cntStart) begin
      phaseCnt <= PHASE_W'(1);
      bitCnt   <= '0;
    end else if (ctl.cntRun) begin
      phaseCnt <= (phaseCnt == PHASE_LAST) ? '0 : phaseCnt + 1'b1;
      if (phaseCnt == PHASE_W'(OVS / 2))
        bitCnt <= bitCnt + 1'b1;
    end
  end

  // data shift register, first bit ends in MSB
  always_ff @(posedge clk) begin
    if (rst)
      shiftReg <= '0;
    else if (ctl.shiftEn)
      shiftReg <= {shiftReg[DATA_BITS-2:0], rxS};
  end

  // output word, flag and strobe
  always_ff @(posedge clk) begin
    if (rst) begin
      dataOut   <= '0;
      stopErr   <= 1'b0;
      dataValid <= 1'b0;
    end else begin
      dataValid <= ctl.capture;
      if (ctl.capture) begin
        dataOut <= shiftReg;
        stopErr <= ~rxS;
      end
    end
  end

endmodule

// File: rtl/osrx_ctrl.sv
module osrx_ctrl
  import osrx_pkg::*;
#(
  parameter int OVS         = 5,
  parameter int START_BITS  = 4,
  parameter int DATA_BITS   = 10,
  parameter int STOP_BITS   = 2,
  localparam int FRAME_BITS = START_BITS + DATA_BITS + STOP_BITS,
  localparam int PHASE_W    = $clog2(OVS),
  localparam int BIT_W      = $clog2(FRAME_BITS + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tickEn,
  input  logic               rxS,
  input  logic [PHASE_W-1:0] phaseCnt,
  input  logic [BIT_W-1:0]   bitCnt,
  input  logic               huntDone,
  output rxCtl_t             ctl,
  output rxState_t           state
);

  localparam logic [BIT_W-1:0]   LAST_START = BIT_W'(START_BITS - 1);
  localparam logic [BIT_W-1:0]   LAST_DATA  = BIT_W'(START_BITS + DATA_BITS - 1);
  localparam logic [BIT_W-1:0]   LAST_STOP  = BIT_W'(FRAME_BITS - 1);
  localparam logic [PHASE_W-1:0] SAMPLE_PH  = PHASE_W'(OVS / 2);

  rxState_t nextState;
  logic     sampleNow;

  assign sampleNow = tickEn && (phaseCnt == SAMPLE_PH);

  always_ff @(posedge clk) begin
    if (rst) state <= ST_HUNT_STOP;
    else     state <= nextState;
  end

  always_comb begin
    ctl       = '0;
    nextState = state;
    case (state)
      ST_HUNT_STOP: begin
        ctl.cntClr = 1'b1;
        if (tickEn) begin
          if (!rxS) begin
            ctl.huntClr = 1'b1;
          end else if (huntDone) begin
            ctl.huntClr = 1'b1;
            nextState   = ST_WAIT_START;
          end else begin
            ctl.huntInc = 1'b1;
          end
        end
      end
      ST_WAIT_START: begin
        ctl.huntClr = 1'b1;
        if (tickEn && !rxS) begin
          ctl.cntStart = 1'b1;
          nextState    = ST_QUAL_START;
        end else begin
          ctl.cntClr = 1'b1;
        end
      end
      ST_QUAL_START: begin
        ctl.huntClr = 1'b1;
        if (tickEn) begin
          if (rxS) begin
            ctl.cntClr = 1'b1;
            nextState  = ST_HUNT_STOP;
          end else begin
            ctl.cntRun = 1'b1;
            if (sampleNow && bitCnt == LAST_START)
              nextState = ST_DATA;
          end
        end
      end
      ST_DATA: begin
        ctl.huntClr = 1'b1;
        if (tickEn) begin
          ctl.cntRun = 1'b1;
          if (sampleNow) begin
            ctl.shiftEn = 1'b1;
            if (bitCnt == LAST_DATA)
              nextState = ST_STOP;
          end
        end
      end
      ST_STOP: begin
        ctl.huntClr = 1'b1;
        if (sampleNow && bitCnt == LAST_STOP) begin
          ctl.capture = 1'b1;
          ctl.cntClr  = 1'b1;
          nextState   = rxS ? ST_WAIT_START : ST_HUNT_STOP;
        end else if (tickEn) begin
          ctl.cntRun = 1'b1;
        end
      end
      default: begin
        ctl.cntClr  = 1'b1;
        ctl.huntClr = 1'b1;
        nextState   = ST_HUNT_STOP;
      end
    endcase
  end

endmodule

// File: rtl/osrx_frame_rx.sv
module osrx_frame_rx
  import osrx_pkg::*;
#(
  parameter int OVS        = 5,
  parameter int START_BITS = 4,
  parameter int DATA_BITS  = 10,
  parameter int STOP_BITS  = 2,
  localparam int FRAME_BITS = START_BITS + DATA_BITS + STOP_BITS,
  localparam int PHASE_W    = $clog2(OVS),
  localparam int BIT_W      = $clog2(FRAME_BITS + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tickEn,
  input  logic                 rxIn,
  output logic [DATA_BITS-1:0] dataOut,
  output logic                 dataValid,
  output logic                 stopErr
);

  rxCtl_t             ctl;
  rxState_t           ctrlState;
  logic               rxSync;
  logic [PHASE_W-1:0] phaseCnt;
  logic [BIT_W-1:0]   bitCnt;
  logic               huntDone;

  osrx_ctrl #(
    .OVS(OVS), .START_BITS(START_BITS), .DATA_BITS(DATA_BITS), .STOP_BITS(STOP_BITS)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .tickEn   (tickEn),
    .rxS      (rxSync),
    .phaseCnt (phaseCnt),
    .bitCnt   (bitCnt),
    .huntDone (huntDone),
    .ctl      (ctl),
    .state    (ctrlState)
  );

  osrx_datapath #(
    .OVS(OVS), .START_BITS(START_BITS), .DATA_BITS(DATA_BITS), .STOP_BITS(STOP_BITS)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .rxIn      (rxIn),
    .ctl       (ctl),
    .rxS       (rxSync),
    .phaseCnt  (phaseCnt),
    .bitCnt    (bitCnt),
    .huntDone  (huntDone),
    .dataOut   (dataOut),
    .dataValid (dataValid),
    .stopErr   (stopErr)
  );

endmodule

// File: rtl/osrx_frame_rx_chk.sv
module osrx_frame_rx_chk
  import osrx_pkg::*;
#(
  parameter int PHASE_W   = 3,
  parameter int BIT_W     = 5,
  parameter int DATA_BITS = 10
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 tickEn,
  input logic                 rxSync,
  input rxState_t             ctrlState,
  input logic [PHASE_W-1:0]   phaseCnt,
  input logic [BIT_W-1:0]     bitCnt,
  input logic [DATA_BITS-1:0] dataOut,
  input logic                 dataValid,
  input logic                 stopErr
);

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!dataValid && !stopErr && dataOut == '0));

  a_r2_hunt_counters_idle: assert property (@(posedge clk) disable iff (rst)
    (ctrlState == ST_HUNT_STOP) |-> (phaseCnt == '0 && bitCnt == '0));

  a_r3_abort_to_hunt: assert property (@(posedge clk) disable iff (rst)
    (ctrlState == ST_QUAL_START && tickEn && rxSync) |=> (ctrlState == ST_HUNT_STOP));

  a_r4_wait_counters_held: assert property (@(posedge clk) disable iff (rst)
    (ctrlState == ST_WAIT_START) |-> (phaseCnt == '0 && bitCnt == '0));

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
    dataValid |=> !dataValid);

  a_r6_pulse_after_tick: assert property (@(posedge clk) disable iff (rst)
    dataValid |-> $past(tickEn));

  a_r6_word_held: assert property (@(posedge clk) disable iff (rst)
    !dataValid |-> ($stable(dataOut) && $stable(stopErr)));

  a_r8_error_rehunts: assert property (@(posedge clk) disable iff (rst)
    (dataValid && stopErr) |-> (ctrlState == ST_HUNT_STOP));

  a_r8_good_rearms: assert property (@(posedge clk) disable iff (rst)
    (dataValid && !stopErr) |-> (ctrlState == ST_WAIT_START));

endmodule

bind osrx_frame_rx osrx_frame_rx_chk #(
  .PHASE_W(PHASE_W), .BIT_W(BIT_W), .DATA_BITS(DATA_BITS)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .tickEn    (tickEn),
  .rxSync    (rxSync),
  .ctrlState (ctrlState),
  .phaseCnt  (phaseCnt),
  .bitCnt    (bitCnt),
  .dataOut   (dataOut),
  .dataValid (dataValid),
  .stopErr   (stopErr)
);

// File: tb/sim_osrx_frame_rx.sv
module sim_osrx_frame_rx;

  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int OVS        = 5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rxIn = 1'b1;
  logic [9:0] dataOut;
  logic       dataValid;
  logic       stopErr;
  logic       tickEn;

  int divCnt = 0;
  int tickCount = 0;
  int checks = 0;
  int errors = 0;
  int validCnt = 0;
  int pulseOverlap = 0;
  int frameMark = 0;
  logic       prevValid = 1'b0;
  logic [9:0] capWord [0:63];
  logic       capErr  [0:63];
  int         capTick [0:63];

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) divCnt <= (divCnt == TICK_DIV-1) ? 0 : divCnt + 1;
  assign tickEn = (divCnt == TICK_DIV-1);

  always @(posedge clk) if (tickEn) tickCount <= tickCount + 1;

  always @(negedge clk) begin
    if (dataValid && validCnt < 64) begin
      capWord[validCnt] = dataOut;
      capErr[validCnt]  = stopErr;
      capTick[validCnt] = tickCount;
    end
    if (dataValid) validCnt++;
    if (dataValid && prevValid) pulseOverlap++;
    prevValid = dataValid;
  end

  osrx_frame_rx u0 (
    .clk(clk), .rst(rst), .tickEn(tickEn), .rxIn(rxIn),
    .dataOut(dataOut), .dataValid(dataValid), .stopErr(stopErr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic waitTick();
    do @(posedge clk); while (!tickEn);
    @(negedge clk);
  endtask

  task automatic drive(input logic lvl, input int nTicks);
    rxIn = lvl;
    for (int i = 0; i < nTicks; i++) waitTick();
  endtask

  task automatic sendFrame(input logic [9:0] w, input logic stop1, input logic stop2);
    frameMark = tickCount;
    drive(1'b0, 4*OVS);
    for (int i = 9; i >= 0; i--) drive(w[i], OVS);
    drive(stop1, OVS);
    drive(stop2, OVS);
    rxIn = 1'b1;
  endtask

  task automatic t_reset();
    check(dataValid == 1'b0, "R1 valid after reset", dataValid, 0);
    check(dataOut == 10'd0, "R1 word after reset", dataOut, 0);
    check(stopErr == 1'b0, "R1 flag after reset", stopErr, 0);
  endtask

  // R2: too short a high period after reset, then a proper one
  task automatic t_stopHunt();
    int base = validCnt;
    drive(1'b1, 5);
    sendFrame(10'h155, 1'b1, 1'b1);
    drive(1'b1, 3);
    check(validCnt == base, "R2 frame without stop qualification", validCnt - base, 0);
    drive(1'b1, 10);
    sendFrame(10'h2A5, 1'b1, 1'b1);
    drive(1'b1, 3);
    check(validCnt == base + 1, "R2 frame after stop qualification", validCnt - base, 1);
    check(capWord[base] == 10'h2A5, "R5 word order", capWord[base], 10'h2A5);
    check(capErr[base] == 1'b0, "R7 good stop", capErr[base], 0);
    check(capTick[base] - frameMark == 78, "R4 R6 strobe timing", capTick[base] - frameMark, 78);
  endtask

  // R8: back-to-back frames with no idle
  task automatic t_backToBack();
    int base = validCnt;
    logic [9:0] w [0:2] = '{10'h3FF, 10'h000, 10'h1C3};
    for (int i = 0; i < 3; i++) sendFrame(w[i], 1'b1, 1'b1);
    drive(1'b1, 3);
    check(validCnt == base + 3, "R8 back-to-back count", validCnt - base, 3);
    for (int i = 0; i < 3; i++)
      check(capWord[base+i] == w[i], "R5 R8 back-to-back word", capWord[base+i], w[i]);
  endtask

  // R3: start shorter than 3.5 bit times is abandoned
  task automatic t_shortStart();
    int base = validCnt;
    drive(1'b0, 17);
    drive(1'b1, 10);
    check(validCnt == base, "R3 short start gives no word", validCnt - base, 0);
    sendFrame(10'h0F0, 1'b1, 1'b1);
    drive(1'b1, 3);
    check(validCnt == base + 1, "R3 frame after short start", validCnt - base, 1);
    check(dataOut == 10'h0F0, "R3 word after short start", dataOut, 10'h0F0);
    drive(1'b1, 10);
    drive(1'b0, 15);
    drive(1'b1, 5);
    sendFrame(10'h155, 1'b1, 1'b1);
    drive(1'b1, 10);
    check(validCnt == base + 1, "R3 short start needs new stop hunt", validCnt - base, 1);
  endtask

  // R7 R8: stop error flagged, then stop hunt required
  task automatic t_stopError();
    int base = validCnt;
    sendFrame(10'h3A1, 1'b1, 1'b0);
    drive(1'b1, 2);
    check(validCnt == base + 1, "R7 error frame delivered", validCnt - base, 1);
    check(stopErr == 1'b1, "R7 stop error flag", stopErr, 1);
    check(dataOut == 10'h3A1, "R7 error frame word", dataOut, 10'h3A1);
    drive(1'b1, 3);
    sendFrame(10'h155, 1'b1, 1'b1);
    drive(1'b1, 10);
    check(validCnt == base + 1, "R8 no frame right after error", validCnt - base, 1);
    check(stopErr == 1'b1, "R6 flag held between strobes", stopErr, 1);
    sendFrame(10'h2A5, 1'b1, 1'b1);
    drive(1'b1, 3);
    check(validCnt == base + 2, "R8 frame after re-hunt", validCnt - base, 2);
    check(stopErr == 1'b0, "R7 flag cleared on good frame", stopErr, 0);
  endtask

  // R7: first stop bit low is ignored
  task automatic t_firstStopLow();
    int base = validCnt;
    sendFrame(10'h0AB, 1'b0, 1'b1);
    sendFrame(10'h301, 1'b1, 1'b1);
    drive(1'b1, 3);
    check(validCnt == base + 2, "R7 first stop ignored count", validCnt - base, 2);
    check(capWord[base] == 10'h0AB && capErr[base] == 1'b0, "R7 first stop low no error",
          capErr[base], 0);
    check(capWord[base+1] == 10'h301, "R8 next frame accepted", capWord[base+1], 10'h301);
  endtask

  // R1: reset mid-frame
  task automatic t_midReset();
    int base = validCnt;
    drive(1'b0, 20);
    drive(1'b1, 15);
    @(negedge clk) rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check(dataOut == 10'd0 && !dataValid && !stopErr, "R1 mid-frame reset clears", dataOut, 0);
    drive(1'b0, 30);
    drive(1'b1, 10);
    check(validCnt == base, "R1 no word from torn frame", validCnt - base, 0);
    sendFrame(10'h11E, 1'b1, 1'b1);
    drive(1'b1, 3);
    check(validCnt == base + 1 && dataOut == 10'h11E, "R1 frame after reset", dataOut, 10'h11E);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_stopHunt();
    t_backToBack();
    t_shortStart();
    t_stopError();
    t_firstStopLow();
    t_midReset();
    check(pulseOverlap == 0, "R6 strobe one cycle wide", pulseOverlap, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule